// File: doc/BRIEF.md
# Packet FIFO Stream Adapter

This block sits between a packet engine and a 256-bit streaming MAC. It joins three clock domains: the engine clock, the MAC transmit clock and the MAC receive clock. On the transmit side the engine pushes words into an asynchronous FIFO. The adapter does not offer a packet to the MAC until the last word of that packet is stored. It learns this from a packet counter in the engine domain, which it passes to the transmit clock as a Gray code. It then streams the packet with valid, ready, start and end markers.

On the receive side, the adapter decides once per packet, when the start marker arrives. If the receive FIFO's write-side fill level is below an admission limit, the whole packet is written. The default limit is 224 of 512 words, which leaves more than 9 KB free for a jumbo frame. Otherwise every word of the packet is discarded. The engine pops received words from a show-ahead read port.

Each FIFO word carries the data, an end-of-packet bit and one flag bit for the last-word empty-byte count. That count is always either 4 or 10 bytes.

Top module: `pkt_stream_bridge`

## Requirements
- R1: During and after reset, `mtx_valid` is low, `eng_rx_avail` is low and `eng_tx_full` is low.
- R2: No transmit word is offered to the MAC while the packet at the head of the transmit FIFO still lacks its end-of-packet word.
- R3: Transmit words leave in the order written, with unchanged data. `mtx_sop` is high on the first word only and `mtx_eop` on the last word only.
- R4: While `mtx_valid` is high and `mtx_ready` is low, `mtx_valid` stays high and `mtx_data` is held. A word counts as taken on a rising edge where valid and ready are both high.
- R5: Once a packet starts, `mtx_valid` has no gap until the end-of-packet word is taken. On the cycle after that, `mtx_valid` is low.
- R6: An empty-byte code of 10 on an end-of-packet word is reproduced as 10 at the far side. Any other code is reproduced as 4. This holds in both directions.
- R7: A receive packet whose start arrives while the receive FIFO's write-side fill level is below ADMIT_LIMIT is stored completely. Its words are read back in order, each with its end-of-packet bit.
- R8: A receive packet whose start arrives while the fill level is at or above ADMIT_LIMIT writes no word at all. A later packet that arrives once room returns is admitted.
- R9: Idle cycles (`mrx_valid` low) inside a receive packet add no words. A valid word without `mrx_sop` while no packet is open is ignored.
- R10: A packet of one word, carrying both start and end markers, is handled correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eng_clk | input | 1 | Engine clock |
| eng_rst_n | input | 1 | Engine-domain reset, active low |
| eng_tx_wr_en | input | 1 | Push one transmit word |
| eng_tx_data | input | DATA_W | Transmit word data |
| eng_tx_eop | input | 1 | Pushed word ends the packet |
| eng_tx_empty_bytes | input | EW | Empty bytes in the last word (4 or 10) |
| eng_tx_full | output | 1 | Transmit FIFO full |
| eng_rx_rd_en | input | 1 | Pop the head receive word |
| eng_rx_avail | output | 1 | Receive FIFO holds at least one word |
| eng_rx_data | output | DATA_W | Head receive word data |
| eng_rx_eop | output | 1 | Head receive word ends a packet |
| eng_rx_empty_bytes | output | EW | Empty bytes of the head word (4 or 10) |
| mtx_clk | input | 1 | MAC transmit clock |
| mtx_rst_n | input | 1 | Transmit-domain reset, active low |
| mtx_ready | input | 1 | MAC accepts a word |
| mtx_valid | output | 1 | Word offered to the MAC |
| mtx_data | output | DATA_W | Offered word data |
| mtx_sop | output | 1 | First word of a packet |
| mtx_eop | output | 1 | Last word of a packet |
| mtx_empty_bytes | output | EW | Empty bytes in the offered word |
| mrx_clk | input | 1 | MAC receive clock |
| mrx_rst_n | input | 1 | Receive-domain reset, active low |
| mrx_valid | input | 1 | MAC receive word valid |
| mrx_data | input | DATA_W | MAC receive word data |
| mrx_sop | input | 1 | First word of a received packet |
| mrx_eop | input | 1 | Last word of a received packet |
| mrx_empty_bytes | input | EW | Empty bytes in the received word |

## Verification
Several internal faults show up at the transmit port within a few transmit cycles:
- A wrong remaining-packet count releases a half-written packet early. The MAC then sees `mtx_valid` during a window in which only part of a packet was pushed.
- A wrong read count freezes transmit.
- A broken read enable produces a repeated or skipped word at the next ready cycle. It also shows as a gap in valid.

A faulty receive admission or flush state shows up once the engine drains the FIFO. The word sequence then contains a dropped packet's words, or lacks an admitted packet's words, or contains a stray word, and the first wrong word points to the packet at fault.

// File: rtl/psa_pkg.sv
package psa_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_UPD, TX_XFER} tx_st_e;
    typedef enum logic [1:0] {RX_IDLE, RX_TAKE, RX_DROP} rx_st_e;
    localparam int CODE_LO = 4;
    localparam int CODE_HI = 10;
endpackage

// File: rtl/psa_gray_xfer.sv
module psa_gray_xfer #(
    parameter int W = 4
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_val,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_val
);
    logic [W-1:0] gray_d, gray_q, s1_q, s2_q;

    always_comb gray_d = src_val ^ (src_val >> 1);

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= gray_d;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_q;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) dst_val[i] = ^(s2_q >> i);
    end
endmodule

// File: rtl/psa_afifo.sv
module psa_afifo #(
    parameter int W  = 258,
    parameter int AW = 9
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    output logic [AW:0]  wr_level,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_word,
    output logic         rd_empty
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr_d, wptr_q, rptr_d, rptr_q, rptr_w, wptr_r;
    logic         wr_ok, rd_ok;

    psa_gray_xfer #(.W(AW+1)) i_rptr_sync (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_val(rptr_q),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_val(rptr_w)
    );
    psa_gray_xfer #(.W(AW+1)) i_wptr_sync (
        .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_val(wptr_q),
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_val(wptr_r)
    );

    always_comb begin
        wr_level = wptr_q - rptr_w;
        wr_ok    = wr_en && (wr_level != DEPTH_V);
        wptr_d   = wr_ok ? wptr_q + (AW+1)'(1) : wptr_q;
        rd_empty = (rptr_q == wptr_r);
        rd_ok    = rd_en && !rd_empty;
        rptr_d   = rd_ok ? rptr_q + (AW+1)'(1) : rptr_q;
        rd_word  = mem[rptr_q[AW-1:0]];
    end

    always_ff @(posedge wr_clk) begin
        if (wr_ok) mem[wptr_q[AW-1:0]] <= wr_word;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wptr_q <= '0;
        else           wptr_q <= wptr_d;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rptr_q <= '0;
        else           rptr_q <= rptr_d;
    end
endmodule

// File: rtl/psa_tx_ctrl.sv
module psa_tx_ctrl
    import psa_pkg::*;
#(
    parameter int W  = 256,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pkt_written,
    input  logic          fifo_empty,
    input  logic [W+1:0]  fifo_word,
    output logic          fifo_rd,
    input  logic          ready,
    output logic          valid,
    output logic [W-1:0]  data,
    output logic          sop,
    output logic          eop,
    output logic          flag10
);
    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] rd_cnt;
        logic          vld;
        logic          sop;
        logic          first;
        logic          eop;
        logic          f10;
        logic [W-1:0]  data;
    } tx_reg_t;

    tx_reg_t r_q, r_d;
    logic [CW-1:0] remain;
    logic take, done;

    always_comb begin
        r_d     = r_q;
        remain  = pkt_written - r_q.rd_cnt;
        done    = r_q.vld && r_q.eop;
        take    = r_q.vld && ready;
        fifo_rd = (r_q.st != TX_IDLE) && ready && !done && !fifo_empty;
        if (take) begin
            r_d.vld = 1'b0;
            r_d.sop = 1'b0;
        end
        if (fifo_rd) begin
            r_d.vld   = 1'b1;
            r_d.data  = fifo_word[W-1:0];
            r_d.f10   = fifo_word[W];
            r_d.eop   = fifo_word[W+1];
            r_d.sop   = r_q.first;
            r_d.first = 1'b0;
        end
        unique case (r_q.st)
            TX_IDLE: if (remain != '0 && !fifo_empty) begin
                r_d.st    = TX_UPD;
                r_d.first = 1'b1;
            end
            TX_UPD: begin
                r_d.rd_cnt = r_q.rd_cnt + CW'(1);
                r_d.st     = TX_XFER;
            end
            TX_XFER: if (take && r_q.eop) r_d.st = TX_IDLE;
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid  = r_q.vld;
    assign data   = r_q.data;
    assign sop    = r_q.sop;
    assign eop    = r_q.eop;
    assign flag10 = r_q.f10;
endmodule

// File: rtl/psa_rx_ctrl.sv
module psa_rx_ctrl
    import psa_pkg::*;
#(
    parameter int W     = 256,
    parameter int AW    = 9,
    parameter int LIMIT = 224
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         sop,
    input  logic         eop,
    input  logic         flag10,
    input  logic [W-1:0] data,
    input  logic [AW:0]  level,
    output logic         wr_en,
    output logic [W+1:0] wr_word,
    output logic         flushing
);
    localparam logic [AW:0] LIM_V = LIMIT[AW:0];

    typedef struct packed {
        rx_st_e       st;
        logic         wen;
        logic [W+1:0] word;
    } rx_reg_t;

    rx_reg_t r_q, r_d;
    logic fin;

    always_comb begin
        r_d      = r_q;
        r_d.wen  = 1'b0;
        r_d.word = {eop, flag10, data};
        fin      = valid && eop;
        unique case (r_q.st)
            RX_IDLE: if (valid && sop) begin
                if (level < LIM_V) begin
                    r_d.wen = 1'b1;
                    if (!eop) r_d.st = RX_TAKE;
                end else if (!eop) begin
                    r_d.st = RX_DROP;
                end
            end
            RX_TAKE: begin
                r_d.wen = valid;
                if (fin) r_d.st = RX_IDLE;
            end
            RX_DROP: if (fin) r_d.st = RX_IDLE;
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_en    = r_q.wen;
    assign wr_word  = r_q.word;
    assign flushing = (r_q.st == RX_DROP);
endmodule

// File: rtl/pkt_stream_bridge.sv
module pkt_stream_bridge
    import psa_pkg::*;
#(
    parameter int DATA_W      = 256,
    parameter int ADDR_W      = 9,
    parameter int ADMIT_LIMIT = 224,
    localparam int EW         = $clog2(DATA_W / 8)
) (
    input  logic              eng_clk,
    input  logic              eng_rst_n,
    input  logic              eng_tx_wr_en,
    input  logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_eop,
    input  logic [EW-1:0]     eng_tx_empty_bytes,
    output logic              eng_tx_full,
    input  logic              eng_rx_rd_en,
    output logic              eng_rx_avail,
    output logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_eop,
    output logic [EW-1:0]     eng_rx_empty_bytes,
    input  logic              mtx_clk,
    input  logic              mtx_rst_n,
    input  logic              mtx_ready,
    output logic              mtx_valid,
    output logic [DATA_W-1:0] mtx_data,
    output logic              mtx_sop,
    output logic              mtx_eop,
    output logic [EW-1:0]     mtx_empty_bytes,
    input  logic              mrx_clk,
    input  logic              mrx_rst_n,
    input  logic              mrx_valid,
    input  logic [DATA_W-1:0] mrx_data,
    input  logic              mrx_sop,
    input  logic              mrx_eop,
    input  logic [EW-1:0]     mrx_empty_bytes
);
    localparam int FW = DATA_W + 2;
    localparam int CW = ADDR_W + 1;
    localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [EW-1:0]   C_LO    = EW'(CODE_LO);
    localparam logic [EW-1:0]   C_HI    = EW'(CODE_HI);

    logic [ADDR_W:0] tx_level, rx_level;
    logic [CW-1:0]   pkt_d, pkt_q, pkt_mtx;
    logic            tx_push, tx_rd, tx_empty, tx_f10;
    logic [FW-1:0]   tx_head, rx_head, rx_wword;
    logic            rx_wen_w, rx_empty, rx_flush_w, rx_full_w;

    // engine side: packets counted at each accepted end-of-packet word
    always_comb begin
        eng_tx_full = (tx_level == DEPTH_V);
        tx_push     = eng_tx_wr_en && !eng_tx_full;
        pkt_d       = (tx_push && eng_tx_eop) ? pkt_q + CW'(1) : pkt_q;
    end

    always_ff @(posedge eng_clk or negedge eng_rst_n) begin
        if (!eng_rst_n) pkt_q <= '0;
        else            pkt_q <= pkt_d;
    end

    psa_gray_xfer #(.W(CW)) i_pkt_sync (
        .src_clk(eng_clk), .src_rst_n(eng_rst_n), .src_val(pkt_q),
        .dst_clk(mtx_clk), .dst_rst_n(mtx_rst_n), .dst_val(pkt_mtx)
    );

    psa_afifo #(.W(FW), .AW(ADDR_W)) i_tx_fifo (
        .wr_clk(eng_clk), .wr_rst_n(eng_rst_n), .wr_en(tx_push),
        .wr_word({eng_tx_eop, (eng_tx_empty_bytes == C_HI), eng_tx_data}),
        .wr_level(tx_level),
        .rd_clk(mtx_clk), .rd_rst_n(mtx_rst_n), .rd_en(tx_rd),
        .rd_word(tx_head), .rd_empty(tx_empty)
    );

    psa_tx_ctrl #(.W(DATA_W), .CW(CW)) i_tx_ctrl (
        .clk(mtx_clk), .rst_n(mtx_rst_n), .pkt_written(pkt_mtx),
        .fifo_empty(tx_empty), .fifo_word(tx_head), .fifo_rd(tx_rd),
        .ready(mtx_ready), .valid(mtx_valid), .data(mtx_data),
        .sop(mtx_sop), .eop(mtx_eop), .flag10(tx_f10)
    );

    assign mtx_empty_bytes = tx_f10 ? C_HI : C_LO;

    psa_rx_ctrl #(.W(DATA_W), .AW(ADDR_W), .LIMIT(ADMIT_LIMIT)) i_rx_ctrl (
        .clk(mrx_clk), .rst_n(mrx_rst_n), .valid(mrx_valid), .sop(mrx_sop),
        .eop(mrx_eop), .flag10(mrx_empty_bytes == C_HI), .data(mrx_data),
        .level(rx_level), .wr_en(rx_wen_w), .wr_word(rx_wword),
        .flushing(rx_flush_w)
    );

    assign rx_full_w = (rx_level == DEPTH_V);

    psa_afifo #(.W(FW), .AW(ADDR_W)) i_rx_fifo (
        .wr_clk(mrx_clk), .wr_rst_n(mrx_rst_n), .wr_en(rx_wen_w),
        .wr_word(rx_wword), .wr_level(rx_level),
        .rd_clk(eng_clk), .rd_rst_n(eng_rst_n), .rd_en(eng_rx_rd_en),
        .rd_word(rx_head), .rd_empty(rx_empty)
    );

    assign eng_rx_avail       = !rx_empty;
    assign eng_rx_data        = rx_head[DATA_W-1:0];
    assign eng_rx_eop         = rx_head[DATA_W+1];
    assign eng_rx_empty_bytes = rx_head[DATA_W] ? C_HI : C_LO;
endmodule

// File: rtl/psa_checker.sv
module psa_checker (
    input logic        mtx_clk,
    input logic        mtx_rst_n,
    input logic        mtx_valid,
    input logic        mtx_ready,
    input logic        mtx_sop,
    input logic        mtx_eop,
    input logic [63:0] mtx_low,
    input logic        mrx_clk,
    input logic        mrx_rst_n,
    input logic        rx_flush,
    input logic        rx_wr_en,
    input logic        rx_full
);
    p_hold_r4: assert property (@(posedge mtx_clk) disable iff (!mtx_rst_n)
        mtx_valid && !mtx_ready |=> mtx_valid && $stable(mtx_low));

    p_gapless_r5: assert property (@(posedge mtx_clk) disable iff (!mtx_rst_n)
        mtx_valid && mtx_ready && !mtx_eop |=> mtx_valid);

    p_end_drop_r5: assert property (@(posedge mtx_clk) disable iff (!mtx_rst_n)
        mtx_valid && mtx_ready && mtx_eop |=> !mtx_valid);

    p_sop_once_r3: assert property (@(posedge mtx_clk) disable iff (!mtx_rst_n)
        mtx_valid && mtx_ready && mtx_sop |=> !mtx_sop);

    p_start_marked_r3: assert property (@(posedge mtx_clk) disable iff (!mtx_rst_n)
        $rose(mtx_valid) |-> mtx_sop);

    p_flush_silent_r8: assert property (@(posedge mrx_clk) disable iff (!mrx_rst_n)
        rx_flush && $past(rx_flush) |-> !rx_wr_en);

    p_no_overflow_r7: assert property (@(posedge mrx_clk) disable iff (!mrx_rst_n)
        rx_wr_en |-> !rx_full);
endmodule

bind pkt_stream_bridge psa_checker i_psa_checker (
    .mtx_clk(mtx_clk), .mtx_rst_n(mtx_rst_n), .mtx_valid(mtx_valid),
    .mtx_ready(mtx_ready), .mtx_sop(mtx_sop), .mtx_eop(mtx_eop),
    .mtx_low(mtx_data[63:0]), .mrx_clk(mrx_clk), .mrx_rst_n(mrx_rst_n),
    .rx_flush(rx_flush_w), .rx_wr_en(rx_wen_w), .rx_full(rx_full_w)
);

// File: tb/test_pkt_stream_bridge.sv
module test_pkt_stream_bridge;
    localparam int DW = 256;
    localparam int AW = 4;
    localparam int LIM = 8;
    localparam int EW = 5;
    localparam int NTX = 12;

    logic eng_clk = 0, mtx_clk = 0, mrx_clk = 0;
    logic eng_rst_n = 0, mtx_rst_n = 0, mrx_rst_n = 0;
    logic eng_tx_wr_en = 0, eng_tx_eop = 0, eng_rx_rd_en = 0, mtx_ready = 0;
    logic [DW-1:0] eng_tx_data = '0, mrx_data = '0;
    logic [EW-1:0] eng_tx_empty_bytes = '0, mrx_empty_bytes = '0;
    logic mrx_valid = 0, mrx_sop = 0, mrx_eop = 0;
    logic eng_tx_full, eng_rx_avail, eng_rx_eop, mtx_valid, mtx_sop, mtx_eop;
    logic [DW-1:0] eng_rx_data, mtx_data;
    logic [EW-1:0] eng_rx_empty_bytes, mtx_empty_bytes;

    int vectors = 0, miscompares = 0;
    bit rd_enable = 0;
    int rx_k = 0;

    always #2.5 eng_clk = ~eng_clk;
    always #3.0 mtx_clk = ~mtx_clk;
    always #3.5 mrx_clk = ~mrx_clk;

    pkt_stream_bridge #(.DATA_W(DW), .ADDR_W(AW), .ADMIT_LIMIT(LIM)) i_pkt_stream_bridge (
        .eng_clk(eng_clk), .eng_rst_n(eng_rst_n), .eng_tx_wr_en(eng_tx_wr_en),
        .eng_tx_data(eng_tx_data), .eng_tx_eop(eng_tx_eop),
        .eng_tx_empty_bytes(eng_tx_empty_bytes), .eng_tx_full(eng_tx_full),
        .eng_rx_rd_en(eng_rx_rd_en), .eng_rx_avail(eng_rx_avail),
        .eng_rx_data(eng_rx_data), .eng_rx_eop(eng_rx_eop),
        .eng_rx_empty_bytes(eng_rx_empty_bytes),
        .mtx_clk(mtx_clk), .mtx_rst_n(mtx_rst_n), .mtx_ready(mtx_ready),
        .mtx_valid(mtx_valid), .mtx_data(mtx_data), .mtx_sop(mtx_sop),
        .mtx_eop(mtx_eop), .mtx_empty_bytes(mtx_empty_bytes),
        .mrx_clk(mrx_clk), .mrx_rst_n(mrx_rst_n), .mrx_valid(mrx_valid),
        .mrx_data(mrx_data), .mrx_sop(mrx_sop), .mrx_eop(mrx_eop),
        .mrx_empty_bytes(mrx_empty_bytes)
    );

    function automatic int tx_len(int p);
        return ((p + 4) % 6) + 1;
    endfunction
    function automatic logic [DW-1:0] tx_word(int p, int i);
        return {8{16'(p), 16'(i)}};
    endfunction
    function automatic int tx_code(int p);
        return (p % 3 == 0) ? 10 : 4;
    endfunction
    function automatic logic [DW-1:0] rx_word(int p, int i);
        return {8{16'hA000 + 16'(p), 16'(i) ^ 16'h5A5A}};
    endfunction
    function automatic int rx_code(int p);
        return (p % 2 == 1) ? 10 : 4;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // transmit writer (engine domain); R2 partial-packet window on packet 0
    task automatic tx_writer();
        bit seen;
        for (int p = 0; p < NTX; p++) begin
            for (int i = 0; i < tx_len(p); i++) begin
                if (p == 0 && i == tx_len(0) - 1) begin
                    eng_tx_wr_en = 0;
                    seen = 0;
                    repeat (80) begin
                        @(negedge eng_clk);
                        if (mtx_valid) seen = 1;
                    end
                    check(!seen, "R2 partial packet released", 64'(seen), 64'd0);
                end
                while (eng_tx_full) begin
                    eng_tx_wr_en = 0;
                    @(negedge eng_clk);
                end
                eng_tx_wr_en = 1;
                eng_tx_data = tx_word(p, i);
                eng_tx_eop = (i == tx_len(p) - 1);
                eng_tx_empty_bytes = (i == tx_len(p) - 1) ? EW'(tx_code(p)) : '0;
                @(negedge eng_clk);
            end
        end
        eng_tx_wr_en = 0;
        eng_tx_eop = 0;
    endtask

    // transmit monitor (MAC transmit domain) with a varying ready pattern
    task automatic tx_monitor();
        int pw = 0, iw = 0, mcyc = 0;
        bit hold_p = 0, gap_p = 0, r;
        logic [DW-1:0] hold_d = '0;
        while (pw < NTX) begin
            @(negedge mtx_clk);
            mcyc++;
            if (hold_p)
                check(mtx_valid && mtx_data == hold_d, "R4 hold under backpressure",
                      mtx_data[63:0], hold_d[63:0]);
            if (gap_p)
                check(mtx_valid, "R5 gap inside packet", 64'(mtx_valid), 64'd1);
            r = !((mcyc % 4) == 1 || (mcyc % 7) == 3);
            mtx_ready = r;
            hold_p = mtx_valid && !r;
            hold_d = mtx_data;
            gap_p = 0;
            if (mtx_valid && r) begin
                check(mtx_data == tx_word(pw, iw) && mtx_sop == (iw == 0) &&
                      mtx_eop == (iw == tx_len(pw) - 1),
                      (tx_len(pw) == 1) ? "R10 single-word tx" : "R3 tx word order/markers",
                      {mtx_data[61:0], mtx_sop, mtx_eop},
                      {tx_word(pw, iw)[61:0], 1'(iw == 0), 1'(iw == tx_len(pw) - 1)});
                if (iw == tx_len(pw) - 1) begin
                    check(mtx_empty_bytes == EW'(tx_code(pw)), "R6 tx empty code",
                          64'(mtx_empty_bytes), 64'(tx_code(pw)));
                    iw = 0;
                    pw++;
                end else begin
                    gap_p = 1;
                    iw++;
                end
            end
        end
        @(negedge mtx_clk);
        check(!mtx_valid, "R5 valid drops after end", 64'(mtx_valid), 64'd0);
        mtx_ready = 1;
    endtask

    task automatic rx_beat(bit v, bit s, bit e, logic [DW-1:0] d, int code);
        mrx_valid = v;
        mrx_sop = s;
        mrx_eop = e;
        mrx_data = d;
        mrx_empty_bytes = EW'(code);
        @(negedge mrx_clk);
    endtask

    task automatic rx_packet(int p, int len, bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) rx_beat(0, 0, 0, '0, 0);
            rx_beat(1, i == 0, i == len - 1, rx_word(p, i),
                    (i == len - 1) ? rx_code(p) : 0);
        end
        repeat (6) rx_beat(0, 0, 0, '0, 0);
    endtask

    // engine-side reader: expected order is packets 1,2,4,5
    initial begin
        int rp_tab[4] = '{1, 2, 4, 5};
        int rl_tab[4] = '{7, 7, 1, 8};
        int q = 0, ri = 0;
        forever begin
            @(negedge eng_clk);
            eng_rx_rd_en = 0;
            if (rd_enable && eng_rx_avail) begin
                if (q < 4) begin
                    check(eng_rx_data == rx_word(rp_tab[q], ri) &&
                          eng_rx_eop == (ri == rl_tab[q] - 1),
                          (rl_tab[q] == 1) ? "R10 single-word rx" : "R7 rx word order",
                          {eng_rx_data[62:0], eng_rx_eop},
                          {rx_word(rp_tab[q], ri)[62:0], 1'(ri == rl_tab[q] - 1)});
                    if (ri == rl_tab[q] - 1) begin
                        check(eng_rx_empty_bytes == EW'(rx_code(rp_tab[q])), "R6 rx empty code",
                              64'(eng_rx_empty_bytes), 64'(rx_code(rp_tab[q])));
                        ri = 0;
                        q++;
                    end else ri++;
                end else begin
                    check(0, "R8/R9 unexpected rx word", eng_rx_data[63:0], 64'd0);
                end
                eng_rx_rd_en = 1;
                rx_k++;
            end
        end
    end

    task automatic rx_flow();
        @(negedge mrx_clk);
        rx_packet(1, 7, 1);
        rx_packet(2, 7, 0);
        rx_packet(3, 5, 1);
        rd_enable = 1;
        wait (rx_k == 14);
        repeat (40) @(negedge eng_clk);
        check(rx_k == 14 && !eng_rx_avail, "R8 dropped packet absent", 64'(rx_k), 64'd14);
        repeat (30) @(negedge mrx_clk);
        rx_packet(4, 1, 0);
        rx_beat(1, 0, 0, rx_word(9, 9), 0);
        repeat (4) rx_beat(0, 0, 0, '0, 0);
        rx_packet(5, 8, 1);
        wait (rx_k >= 23);
        repeat (40) @(negedge eng_clk);
        check(rx_k == 23 && !eng_rx_avail, "R9 stray/gaps add no words", 64'(rx_k), 64'd23);
    endtask

    initial begin
        repeat (150000) @(posedge eng_clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired act=%0d exp=done", rx_k);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge eng_clk);
        check(!mtx_valid && !eng_rx_avail && !eng_tx_full, "R1 state in reset",
              {61'd0, mtx_valid, eng_rx_avail, eng_tx_full}, 64'd0);
        eng_rst_n = 1;
        mtx_rst_n = 1;
        mrx_rst_n = 1;
        repeat (3) @(negedge eng_clk);
        check(!mtx_valid && !eng_rx_avail && !eng_tx_full, "R1 state after reset",
              {61'd0, mtx_valid, eng_rx_avail, eng_tx_full}, 64'd0);
        fork
            tx_writer();
            tx_monitor();
            rx_flow();
        join
        repeat (10) @(negedge eng_clk);
        summary();
        $finish;
    end
endmodule